// File: doc/BRIEF.md
# Independent Windowed Watchdog

This block is a watchdog that counts on its own slow clock, separate from the bus clock that software writes with. An 8-bit prescaler divides the watchdog clock. Each prescaler tick lowers a 12-bit down-counter by one. Software keeps the watchdog alive by writing a fixed refresh key, which reloads the counter. If the counter runs out, the block raises a reset request. It also raises one if a refresh comes while the counter is still above a programmable window value, which means the refresh came too early. The reset generator that acts on this request lives outside the block.

Counting can begin in two ways. A hardware strap makes the block run straight out of reset, or software writes a start key. Once the block is running, nothing but a reset stops it. The prescaler, reload and window settings are protected: they can only be written after an unlock key. Every register write crosses into the watchdog clock domain through a single-entry toggle handshake. A busy flag in the bus domain stays high until the watchdog domain has taken the write. A debug-halt input freezes counting. A timer-mode strap turns the block into a free-running timeout timer: on expiry it sets a flag and reloads, and it never requests a reset.

Top module: `indep_wdog`

## Requirements
- R1: After reset, rst_req, expired and busy are 0, count is 12'hFFF, and running is 0 when hw_en is 0.
- R2: Writes to the prescaler (address 1, data bits 7:0), reload (address 2, data bits 11:0) and window (address 3, data bits 11:0) registers are ignored unless key 16'h6996 was the last value written to the key register (address 0). Any other key value locks them again.
- R3: Writing 16'hC3C3 to the key register starts a stopped watchdog with count loaded from the reload value. A key value that is not one of the three keys has no effect.
- R4: With prescaler value P, count falls by exactly one every P+1 watchdog clock cycles.
- R5: When a tick arrives with count at 0 and timer_mode is 0, rst_req rises and stays high until reset, and count stops changing.
- R6: Writing 16'hA5A5 to the key register while running, with count at or below the window value, reloads count from the reload value.
- R7: A refresh key write applied while count is above the window value, with timer_mode 0, raises rst_req.
- R8: A refresh applied with count at or below the window value does not raise rst_req.
- R9: While dbg_halt is 1, count holds its value. Counting resumes at the same rate once dbg_halt returns to 0.
- R10: With timer_mode 1, a tick at count 0 sets expired and reloads count, and rst_req never rises. A refresh clears expired.
- R11: With hw_en 1 the watchdog runs straight out of reset with no start key. Once running is 1 it stays 1 until reset.
- R12: busy is 1 from the edge after an accepted write until the watchdog domain has applied it. Writes arriving while busy is 1 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock for register writes |
| bus_rst_n | input | 1 | Active-low async reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| busy | output | 1 | A write is in flight to the watchdog domain |
| wdg_clk | input | 1 | Independent watchdog clock |
| wdg_rst_n | input | 1 | Active-low async reset, watchdog domain |
| hw_en | input | 1 | Strap: run from reset |
| timer_mode | input | 1 | Strap: timeout-timer mode instead of reset request |
| dbg_halt | input | 1 | Freezes counting (watchdog domain) |
| count | output | 12 | Current down-counter value |
| running | output | 1 | Watchdog is counting |
| rst_req | output | 1 | Sticky reset request |
| expired | output | 1 | Timeout flag in timer mode |

## Verification
The bench targets the window boundary. It refreshes once inside the window and once just after a reload, when the count is still high. A design with the comparison reversed or off by the window sense would either reset a well-behaved program or let an early refresh through. It times the count exactly around zero to catch an expiry one tick early or late. It also measures the tick spacing to catch a prescaler that divides by P instead of P+1. It writes a second time while busy: a design that lets this write through would change the prescaler, and the measured rate would show it. A locked register write and a wrong key are checked through count and running, which exposes key decoding that is too loose.

// File: rtl/iwdg_pkg.sv
package iwdg_pkg;
   typedef enum logic [2:0] {
      OP_NONE, OP_REFRESH, OP_START, OP_PRESC, OP_RELOAD, OP_WINDOW
   } wdg_op_e;

   localparam logic [1:0] ADDR_KEY    = 2'd0;
   localparam logic [1:0] ADDR_PRESC  = 2'd1;
   localparam logic [1:0] ADDR_RELOAD = 2'd2;
   localparam logic [1:0] ADDR_WINDOW = 2'd3;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdg_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/wdg_regif.sv
module wdg_regif import iwdg_pkg::*; #(
   parameter int KEY_W   = 16,
   parameter int CNT_W   = 12,
   parameter int PRESC_W = 8,
   parameter logic [KEY_W-1:0] KEY_REFRESH = 16'hA5A5,
   parameter logic [KEY_W-1:0] KEY_START   = 16'hC3C3,
   parameter logic [KEY_W-1:0] KEY_UNLOCK  = 16'h6996
) (
   input  logic             bus_clk,
   input  logic             bus_rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [KEY_W-1:0] wr_data,
   output logic             put,
   output wdg_op_e          put_op,
   output logic [CNT_W-1:0] put_data
);
   logic unlocked;
   logic key_wr;

   assign key_wr = wr_en && (wr_addr == ADDR_KEY);

   // lock state: only the unlock key opens the config registers
   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n)  unlocked <= 1'b0;
      else if (key_wr) unlocked <= (wr_data == KEY_UNLOCK);
   end

   always_comb begin
      put      = 1'b0;
      put_op   = OP_NONE;
      put_data = '0;
      if (wr_en) begin
         unique case (wr_addr)
            ADDR_KEY: begin
               if (wr_data == KEY_REFRESH) begin
                  put = 1'b1; put_op = OP_REFRESH;
               end else if (wr_data == KEY_START) begin
                  put = 1'b1; put_op = OP_START;
               end
            end
            ADDR_PRESC: if (unlocked) begin
               put = 1'b1; put_op = OP_PRESC;
               put_data = CNT_W'(wr_data[PRESC_W-1:0]);
            end
            ADDR_RELOAD: if (unlocked) begin
               put = 1'b1; put_op = OP_RELOAD;
               put_data = wr_data[CNT_W-1:0];
            end
            ADDR_WINDOW: if (unlocked) begin
               put = 1'b1; put_op = OP_WINDOW;
               put_data = wr_data[CNT_W-1:0];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wdg_mailbox.sv
module wdg_mailbox import iwdg_pkg::*; #(
   parameter int DATA_W = 12,
   parameter int STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              put,
   input  wdg_op_e           put_op,
   input  logic [DATA_W-1:0] put_data,
   output logic              busy,
   input  logic              wdg_clk,
   input  logic              wdg_rst_n,
   output logic              fire,
   output wdg_op_e           fire_op,
   output logic [DATA_W-1:0] fire_data
);
   logic              req_tgl, ack_b, req_w, seen;
   wdg_op_e           hold_op;
   logic [DATA_W-1:0] hold_data;

   assign busy = req_tgl ^ ack_b;

   // bus side: one entry, held steady until the ack returns
   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         req_tgl   <= 1'b0;
         hold_op   <= OP_NONE;
         hold_data <= '0;
      end else if (put && !busy) begin
         req_tgl   <= ~req_tgl;
         hold_op   <= put_op;
         hold_data <= put_data;
      end
   end

   wdg_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(wdg_clk), .rst_n(wdg_rst_n), .d(req_tgl), .q(req_w));

   always_ff @(posedge wdg_clk or negedge wdg_rst_n) begin
      if (!wdg_rst_n) seen <= 1'b0;
      else            seen <= req_w;
   end

   assign fire      = req_w ^ seen;
   assign fire_op   = hold_op;
   assign fire_data = hold_data;

   wdg_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(seen), .q(ack_b));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               clr,
   input  logic [PRESC_W-1:0] div,
   output logic               tick
);
   logic [PRESC_W-1:0] acc;

   // >= keeps the period bounded if the divisor drops below acc
   assign tick = en && (acc >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (tick) acc <= '0;
      else if (en)   acc <= acc + 1'b1;
   end
endmodule

// File: rtl/wdg_core.sv
module wdg_core import iwdg_pkg::*; #(
   parameter int CNT_W   = 12,
   parameter int PRESC_W = 8,
   parameter logic [PRESC_W-1:0] DEF_PRESC  = '0,
   parameter logic [CNT_W-1:0]   DEF_RELOAD = '1,
   parameter logic [CNT_W-1:0]   DEF_WINDOW = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hw_en,
   input  logic               timer_mode,
   input  logic               dbg_halt,
   input  logic               fire,
   input  wdg_op_e            op,
   input  logic [CNT_W-1:0]   data,
   input  logic               tick,
   output logic               cnt_en,
   output logic               cnt_clr,
   output logic [PRESC_W-1:0] presc,
   output logic [CNT_W-1:0]   count,
   output logic               running,
   output logic               rst_req,
   output logic               expired
);
   logic [CNT_W-1:0] reload, window;
   logic             early;

   assign cnt_en  = running && !dbg_halt && !rst_req;
   assign cnt_clr = fire && (op == OP_REFRESH || op == OP_START);
   assign early   = count > window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc   <= DEF_PRESC;
         reload  <= DEF_RELOAD;
         window  <= DEF_WINDOW;
         count   <= DEF_RELOAD;
         running <= hw_en;
         rst_req <= 1'b0;
         expired <= 1'b0;
      end else if (fire) begin
         unique case (op)
            OP_REFRESH: if (running && !rst_req) begin
               if (!early) begin
                  count   <= reload;
                  expired <= 1'b0;
               end else if (!timer_mode) begin
                  rst_req <= 1'b1;
               end
            end
            OP_START: if (!running) begin
               running <= 1'b1;
               count   <= reload;
            end
            OP_PRESC:  presc  <= data[PRESC_W-1:0];
            OP_RELOAD: reload <= data;
            OP_WINDOW: window <= data;
            default: ;
         endcase
      end else if (tick) begin
         if (count != '0) begin
            count <= count - 1'b1;
         end else if (timer_mode) begin
            expired <= 1'b1;
            count   <= reload;
         end else begin
            rst_req <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/indep_wdog.sv
module indep_wdog import iwdg_pkg::*; #(
   parameter int PRESC_W     = 8,
   parameter int CNT_W       = 12,
   parameter int KEY_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter logic [PRESC_W-1:0] DEF_PRESC  = '0,
   parameter logic [CNT_W-1:0]   DEF_RELOAD = '1,
   parameter logic [CNT_W-1:0]   DEF_WINDOW = '1,
   parameter logic [KEY_W-1:0]   KEY_REFRESH = 16'hA5A5,
   parameter logic [KEY_W-1:0]   KEY_START   = 16'hC3C3,
   parameter logic [KEY_W-1:0]   KEY_UNLOCK  = 16'h6996
) (
   input  logic             bus_clk,
   input  logic             bus_rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [KEY_W-1:0] wr_data,
   output logic             busy,
   input  logic             wdg_clk,
   input  logic             wdg_rst_n,
   input  logic             hw_en,
   input  logic             timer_mode,
   input  logic             dbg_halt,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             rst_req,
   output logic             expired
);
   generate
      if (PRESC_W > CNT_W) begin : g_bad_presc
         $error("prescaler wider than counter payload");
      end
      if (CNT_W > KEY_W) begin : g_bad_key
         $error("write data narrower than counter");
      end
   endgenerate

   logic               put, cmd_fire, tick, cnt_en, cnt_clr;
   wdg_op_e            put_op, cmd_op;
   logic [CNT_W-1:0]   put_data, cmd_data;
   logic [PRESC_W-1:0] presc;

   wdg_regif #(
      .KEY_W(KEY_W), .CNT_W(CNT_W), .PRESC_W(PRESC_W),
      .KEY_REFRESH(KEY_REFRESH), .KEY_START(KEY_START), .KEY_UNLOCK(KEY_UNLOCK)
   ) u_regif (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .put(put), .put_op(put_op), .put_data(put_data));

   wdg_mailbox #(.DATA_W(CNT_W), .STAGES(SYNC_STAGES)) u_mbox (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .put(put), .put_op(put_op),
      .put_data(put_data), .busy(busy), .wdg_clk(wdg_clk), .wdg_rst_n(wdg_rst_n),
      .fire(cmd_fire), .fire_op(cmd_op), .fire_data(cmd_data));

   wdg_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk(wdg_clk), .rst_n(wdg_rst_n), .en(cnt_en), .clr(cnt_clr),
      .div(presc), .tick(tick));

   wdg_core #(
      .CNT_W(CNT_W), .PRESC_W(PRESC_W), .DEF_PRESC(DEF_PRESC),
      .DEF_RELOAD(DEF_RELOAD), .DEF_WINDOW(DEF_WINDOW)
   ) u_core (
      .clk(wdg_clk), .rst_n(wdg_rst_n), .hw_en(hw_en), .timer_mode(timer_mode),
      .dbg_halt(dbg_halt), .fire(cmd_fire), .op(cmd_op), .data(cmd_data),
      .tick(tick), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .presc(presc),
      .count(count), .running(running), .rst_req(rst_req), .expired(expired));
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
   parameter int CNT_W = 12
) (
   input logic             wdg_clk,
   input logic             wdg_rst_n,
   input logic [CNT_W-1:0] count,
   input logic             running,
   input logic             rst_req,
   input logic             timer_mode,
   input logic             dbg_halt,
   input logic             cmd_fire
);
   assert_rst_sticky_R5: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
      rst_req |=> rst_req);

   assert_rst_frozen_R5: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
      rst_req |=> $stable(count));

   assert_no_stop_R11: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
      running |=> running);

   assert_halt_freeze_R9: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
      (dbg_halt && !cmd_fire) |=> $stable(count));

   assert_single_step_R4: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
      (!cmd_fire && count != '0) |=>
         (count == $past(count) || count == CNT_W'($past(count) - 1'b1)));

   assert_timer_no_rst_R10: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
      timer_mode |-> !rst_req);
endmodule

bind indep_wdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
   .wdg_clk(wdg_clk), .wdg_rst_n(wdg_rst_n), .count(count), .running(running),
   .rst_req(rst_req), .timer_mode(timer_mode), .dbg_halt(dbg_halt),
   .cmd_fire(cmd_fire));

// File: tb/indep_wdog_tb.sv
module indep_wdog_tb;
   import iwdg_pkg::*;

   localparam int BUS_PERIOD = 10;
   localparam int WDG_PERIOD = 70;
   localparam logic [15:0] K_REF = 16'hA5A5;
   localparam logic [15:0] K_STA = 16'hC3C3;
   localparam logic [15:0] K_UNL = 16'h6996;

   logic bus_clk = 0, wdg_clk = 0;
   logic bus_rst_n = 0, wdg_rst_n = 0;
   logic wr_en = 0;
   logic [1:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic hw_en = 0, timer_mode = 0, dbg_halt = 0;
   logic busy, running, rst_req, expired;
   logic [11:0] count;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
   always #(WDG_PERIOD/2) wdg_clk = ~wdg_clk;

   indep_wdog u_dut (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .wdg_clk(wdg_clk), .wdg_rst_n(wdg_rst_n),
      .hw_en(hw_en), .timer_mode(timer_mode), .dbg_halt(dbg_halt),
      .count(count), .running(running), .rst_req(rst_req), .expired(expired));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wwait(input int n);
      repeat (n) @(negedge wdg_clk);
   endtask

   task automatic reset_dut(input logic hw, input logic tm);
      wr_en = 0; dbg_halt = 0; hw_en = hw; timer_mode = tm;
      bus_rst_n = 0; wdg_rst_n = 0;
      wwait(3);
      bus_rst_n = 1; wdg_rst_n = 1;
      wwait(2);
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge bus_clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge bus_clk); wr_en = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000 && busy; i++) @(negedge bus_clk);
      wwait(2);
   endtask

   task automatic wr_idle(input logic [1:0] a, input logic [15:0] d);
      bus_wr(a, d);
      wait_idle();
   endtask

   // wait for a decrement so the next tick phase is known
   task automatic sync_tick(output int c);
      int c0 = count;
      for (int i = 0; i < 100 && count == c0; i++) @(negedge wdg_clk);
      c = count;
   endtask

   task automatic t_reset_and_keys();
      reset_dut(0, 0);
      chk("R1 rst_req", rst_req, 0);
      chk("R1 expired", expired, 0);
      chk("R1 busy", busy, 0);
      chk("R1 running", running, 0);
      chk("R1 count", count, 12'hFFF);
      bus_wr(ADDR_KEY, 16'h1234);
      wwait(8);
      chk("R3 wrong key keeps stopped", running, 0);
      bus_wr(ADDR_RELOAD, 16'd100);
      chk("R2 locked write not accepted (busy)", busy, 0);
      wr_idle(ADDR_KEY, K_STA);
      chk("R3 start key runs", running, 1);
      chk("R2 locked reload ignored", int'(count > 4000), 1);
      wr_idle(ADDR_KEY, K_UNL);
      wr_idle(ADDR_KEY, K_REF);
      bus_wr(ADDR_RELOAD, 16'd100);
      chk("R2 relocked by other key", busy, 0);
      wr_idle(ADDR_KEY, K_UNL);
      wr_idle(ADDR_RELOAD, 16'd100);
      wr_idle(ADDR_KEY, K_REF);
      chk("R2 unlocked reload applied", int'(count <= 100 && count > 80), 1);
   endtask

   task automatic t_rate();
      int c;
      reset_dut(0, 0);
      wr_idle(ADDR_KEY, K_UNL);
      wr_idle(ADDR_PRESC, 16'd3);
      wr_idle(ADDR_KEY, K_STA);
      sync_tick(c);
      wwait(15);
      chk("R4 presc 3 after 15 cycles", count, c - 3);
      wwait(1);
      chk("R4 presc 3 after 16 cycles", count, c - 4);
   endtask

   task automatic t_busy();
      int c;
      reset_dut(0, 0);
      wr_idle(ADDR_KEY, K_UNL);
      bus_wr(ADDR_PRESC, 16'd7);
      chk("R12 busy after write", busy, 1);
      bus_wr(ADDR_PRESC, 16'd0);
      wait_idle();
      chk("R12 busy clears", busy, 0);
      wr_idle(ADDR_KEY, K_STA);
      sync_tick(c);
      wwait(7);
      chk("R12 dropped write, still /8 at 7", count, c);
      wwait(1);
      chk("R12 dropped write, /8 at 8", count, c - 1);
   endtask

   task automatic t_timeout();
      int c;
      reset_dut(0, 0);
      wr_idle(ADDR_KEY, K_UNL);
      wr_idle(ADDR_RELOAD, 16'd30);
      wr_idle(ADDR_KEY, K_STA);
      c = count;
      wwait(c);
      chk("R5 count reaches 0", count, 0);
      chk("R5 no request at 0", rst_req, 0);
      wwait(1);
      chk("R5 request on tick at 0", rst_req, 1);
      wwait(5);
      chk("R5 request sticky", rst_req, 1);
      chk("R5 count frozen", count, 0);
   endtask

   task automatic t_window();
      reset_dut(0, 0);
      wr_idle(ADDR_KEY, K_UNL);
      wr_idle(ADDR_RELOAD, 16'd200);
      wr_idle(ADDR_WINDOW, 16'd50);
      wr_idle(ADDR_KEY, K_STA);
      for (int i = 0; i < 400 && count > 40; i++) @(negedge wdg_clk);
      wr_idle(ADDR_KEY, K_REF);
      chk("R8 in-window refresh no request", rst_req, 0);
      chk("R6 refresh reloads", int'(count >= 150 && count <= 200), 1);
      wr_idle(ADDR_KEY, K_REF);
      chk("R7 early refresh requests reset", rst_req, 1);
   endtask

   task automatic t_halt();
      int c;
      reset_dut(0, 0);
      wr_idle(ADDR_KEY, K_UNL);
      wr_idle(ADDR_RELOAD, 16'd100);
      wr_idle(ADDR_KEY, K_STA);
      dbg_halt = 1;
      wwait(1);
      c = count;
      wwait(10);
      chk("R9 count frozen in halt", count, c);
      dbg_halt = 0;
      wwait(5);
      chk("R9 resumes after halt", count, c - 5);
   endtask

   task automatic t_timer();
      reset_dut(0, 1);
      wr_idle(ADDR_KEY, K_UNL);
      wr_idle(ADDR_PRESC, 16'd15);
      wr_idle(ADDR_RELOAD, 16'd5);
      wr_idle(ADDR_KEY, K_STA);
      for (int i = 0; i < 300 && !expired; i++) @(negedge wdg_clk);
      chk("R10 expired set", expired, 1);
      chk("R10 reloaded on expiry", count, 5);
      chk("R10 no reset request", rst_req, 0);
      wr_idle(ADDR_KEY, K_REF);
      chk("R10 refresh clears expired", expired, 0);
   endtask

   task automatic t_strap();
      int c;
      reset_dut(1, 0);
      chk("R11 strap runs from reset", running, 1);
      c = count;
      wwait(5);
      chk("R11 strap counts", count, c - 5);
      wr_idle(ADDR_KEY, K_UNL);
      bus_wr(ADDR_KEY, 16'h0000);
      wwait(8);
      chk("R11 cannot be stopped", running, 1);
   endtask

   initial begin
      #(WDG_PERIOD * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset_and_keys();
      t_rate();
      t_busy();
      t_timeout();
      t_window();
      t_halt();
      t_timer();
      t_strap();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule